// File: doc/BRIEF.md
# Spread-Spectrum Switching Cycle Timer

This block sets the switching-cycle timing for a peak-current-mode power converter controller. It runs from a fixed system clock. Each switching cycle starts with a gate-on request and a one-clock start pulse. The on-time then ends for one of three reasons: the current comparator trips, the duty limit is reached, or a trip arrives during the blanking window. A one-clock strobe marks the end of the on-time and a two-bit code gives the reason. The current comparator result reaches the block as a synchronous digital input.

A mode input selects one of two nominal switching rates. The slow rate has a period of `PER_SLOW` clocks, which is about 30 kHz. The fast rate has half that period, which is about 60 kHz. The period follows a triangular sweep of roughly ±7 % around the nominal value, which spreads the switching harmonics over a band. The sweep changes the period in equal steps at cycle boundaries. In fast mode the sweep advances only every second cycle, so the sweep repeats at about the same rate (near 260 Hz) in both modes. The on-time is held for a minimum blanking window so that a turn-on spike cannot end the pulse. It is cut at 75 % of the current period.

Top module: `pwmj_timer`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `gate_on`, `cyc_start` and `end_stb` are low. The sweep index resets to 0 and its direction resets to rising.
- R2: The period P is the number of clocks from one `cyc_start` pulse to the next. With the sweep index at 0, P = `PER_SLOW` when `fast_mode`=0 and P = `PER_SLOW/2` when `fast_mode`=1.
- R3: P equals the nominal period plus k·S, where S = floor(floor(nominal·7/100)/`QSTEPS`). The sweep index k moves up by one per step from 0 until it reaches `QSTEPS`, then down until it reaches −`QSTEPS`, then up again. k steps at every cycle boundary in slow mode and at every second cycle boundary in fast mode.
- R4: When no trip occurs, the gate stays high for floor(3·P/4) clocks. The on-time then ends with cause code 2'b10.
- R5: A trip seen n clocks after the gate rose, with n ≥ `BLANK`, ends the on-time on that clock with cause code 2'b01. If a trip and the duty limit occur on the same clock, the trip wins.
- R6: The gate stays high for at least `BLANK` clocks. A trip seen during blanking is latched. The gate then falls exactly `BLANK` clocks after it rose, with cause code 2'b11.
- R7: While `en` is low, `gate_on`, `cyc_start` and `end_stb` stay low and the sweep holds its position. When `en` returns high, a new cycle begins at once. That cycle has the period that was in use when `en` fell.
- R8: `cyc_start` is a one-clock pulse on the same clock that `gate_on` rises. `end_stb` is a one-clock pulse on the clock that `gate_on` falls, and `end_cause` is valid with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the gate off and pauses the sweep |
| fast_mode | input | 1 | 0 selects the slow nominal period, 1 the fast (half) period |
| trip | input | 1 | Synchronous current-comparator trip |
| gate_on | output | 1 | Gate-on request |
| cyc_start | output | 1 | One-clock pulse at the start of each switching cycle |
| end_stb | output | 1 | One-clock pulse when the on-time ends |
| end_cause | output | 2 | Cause of the on-time end: 01 trip, 10 duty limit, 11 trip during blanking |

## Verification
A wrong sweep index or direction shows up at the next `cyc_start`. The start-to-start interval is off by a multiple of the step, and the duty-limit gate width that follows changes as well. A corrupted cycle counter or blanking latch shows up within the same cycle, as a gate width or cause code that differs from the expected value at the next `end_stb`. The bench compares every output on every clock against a behavioural model. Errors therefore appear on the clock where they first reach a port, and the directed period and width lists point to the requirement involved.

// File: rtl/pwmj_pkg.sv
package pwmj_pkg;

    // Cause of the on-time end, as carried with the end strobe.
    typedef enum logic [1:0] {
        END_NONE  = 2'b00,
        END_TRIP  = 2'b01,
        END_MAXD  = 2'b10,
        END_EARLY = 2'b11
    } end_cause_e;

    typedef enum logic {
        SWEEP_UP = 1'b0,
        SWEEP_DN = 1'b1
    } sweep_dir_e;

    // Sweep depth in percent of the nominal period.
    localparam int JIT_PCT = 7;

    // Period change per sweep step for a given nominal period.
    function automatic int jit_step(input int nom, input int qsteps);
        return (nom * JIT_PCT / 100) / qsteps;
    endfunction

    // Longest possible on-time for a checker bound: duty limit of the widest period.
    function automatic int max_on(input int per_slow);
        return ((per_slow + per_slow * JIT_PCT / 100) * 3) / 4;
    endfunction

endpackage

// File: rtl/pwmj_sweep.sv
module pwmj_sweep
    import pwmj_pkg::*;
#(
    parameter int PER_SLOW = 4166,
    parameter int QSTEPS   = 29,
    parameter int PW       = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          fast,
    input  logic          wrap,
    output logic [PW-1:0] period
);

    localparam int NOM_S  = PER_SLOW;
    localparam int NOM_F  = PER_SLOW / 2;
    localparam int STEP_S = jit_step(NOM_S, QSTEPS);
    localparam int STEP_F = jit_step(NOM_F, QSTEPS);
    localparam int KW     = $clog2(QSTEPS + 1) + 2;

    logic signed [KW-1:0] k, k_nx;
    sweep_dir_e           dir, dir_nx;
    logic                 pace;
    logic                 advance;

    function automatic logic [PW-1:0] period_of(input logic f, input logic signed [KW-1:0] kk);
        int nom;
        int st;
        nom = f ? NOM_F : NOM_S;
        st  = f ? STEP_F : STEP_S;
        return PW'(nom + int'(kk) * st);
    endfunction

    // Triangular walk of the sweep index; fast mode steps every other cycle.
    always_comb begin
        advance = !fast || pace;
        k_nx    = k;
        dir_nx  = dir;
        if (advance) begin
            if (dir == SWEEP_UP) begin
                k_nx = k + 1'b1;
                if (k_nx == KW'(QSTEPS)) dir_nx = SWEEP_DN;
            end else begin
                k_nx = k - 1'b1;
                if (k_nx == KW'(-QSTEPS)) dir_nx = SWEEP_UP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            k      <= '0;
            dir    <= SWEEP_UP;
            pace   <= 1'b0;
            period <= PW'(NOM_S);
        end else if (!en) begin
            period <= period_of(fast, k);
        end else if (wrap) begin
            k      <= k_nx;
            dir    <= dir_nx;
            pace   <= fast ? ~pace : 1'b0;
            period <= period_of(fast, k_nx);
        end
    end

endmodule

// File: rtl/pwmj_phase.sv
module pwmj_phase
    import pwmj_pkg::*;
#(
    parameter int PW    = 13,
    parameter int BLANK = 38
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          trip,
    input  logic [PW-1:0] period,
    output logic          wrap,
    output logic          gate_on,
    output logic          cyc_start,
    output logic          end_stb,
    output end_cause_e    end_cause
);

    logic [PW-1:0] cnt;
    logic          early;
    logic [PW+1:0] prod;
    logic [PW-1:0] dlim;
    logic          in_blank;
    end_cause_e    fin;

    assign prod     = {2'b00, period} * (PW+2)'(3);
    assign dlim     = prod[PW+1:2];
    assign wrap     = en && (cnt == period - 1'b1);
    assign in_blank = gate_on && (cnt != '0) && (cnt < PW'(BLANK));

    // Decide whether this clock ends the on-time and why.
    always_comb begin
        fin = END_NONE;
        if (gate_on && (cnt != '0) && !in_blank) begin
            if (trip || early)    fin = early ? END_EARLY : END_TRIP;
            else if (cnt == dlim) fin = END_MAXD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            gate_on   <= 1'b0;
            early     <= 1'b0;
            cyc_start <= 1'b0;
            end_stb   <= 1'b0;
            end_cause <= END_NONE;
        end else if (!en) begin
            cnt       <= '0;
            gate_on   <= 1'b0;
            early     <= 1'b0;
            cyc_start <= 1'b0;
            end_stb   <= 1'b0;
        end else begin
            cyc_start <= (cnt == '0);
            end_stb   <= (fin != END_NONE);
            if (fin != END_NONE) begin
                end_cause <= fin;
                gate_on   <= 1'b0;
            end
            if (cnt == '0) begin
                gate_on <= 1'b1;
                early   <= 1'b0;
            end else if (in_blank && trip) begin
                early <= 1'b1;
            end
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwmj_timer.sv
module pwmj_timer
    import pwmj_pkg::*;
#(
    parameter int PER_SLOW = 4166,
    parameter int QSTEPS   = 29,
    parameter int BLANK    = 38
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       fast_mode,
    input  logic       trip,
    output logic       gate_on,
    output logic       cyc_start,
    output logic       end_stb,
    output logic [1:0] end_cause
);

    localparam int PW = $clog2(PER_SLOW * 2);

    logic [PW-1:0] period;
    logic          wrap;
    end_cause_e    cause_e;

    pwmj_sweep #(
        .PER_SLOW(PER_SLOW),
        .QSTEPS  (QSTEPS),
        .PW      (PW)
    ) u_sweep (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .fast  (fast_mode),
        .wrap  (wrap),
        .period(period)
    );

    pwmj_phase #(
        .PW   (PW),
        .BLANK(BLANK)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .trip     (trip),
        .period   (period),
        .wrap     (wrap),
        .gate_on  (gate_on),
        .cyc_start(cyc_start),
        .end_stb  (end_stb),
        .end_cause(cause_e)
    );

    assign end_cause = cause_e;

endmodule

// File: rtl/pwmj_chk.sv
module pwmj_chk
    import pwmj_pkg::*;
#(
    parameter int PER_SLOW = 4166,
    parameter int QSTEPS   = 29,
    parameter int BLANK    = 38
) (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       gate_on,
    input logic       cyc_start,
    input logic       end_stb,
    input logic [1:0] end_cause
);

    localparam int MAXRUN = max_on(PER_SLOW) + 1;

    logic [31:0] run;

    always_ff @(posedge clk) begin
        if (rst)          run <= '0;
        else if (gate_on) run <= run + 1;
        else              run <= '0;
    end

    a_r6_min_on: assert property (@(posedge clk) disable iff (rst)
        end_stb |-> run >= 32'(BLANK));

    a_r4_duty_bound: assert property (@(posedge clk) disable iff (rst)
        gate_on |-> run <= 32'(MAXRUN));

    a_r8_end_falls: assert property (@(posedge clk) disable iff (rst)
        end_stb |-> (!gate_on && $past(gate_on)));

    a_r8_start_rises: assert property (@(posedge clk) disable iff (rst)
        cyc_start |-> gate_on);

    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!gate_on && !cyc_start && !end_stb));

    a_r5_cause_valid: assert property (@(posedge clk) disable iff (rst)
        end_stb |-> end_cause != 2'b00);

endmodule

bind pwmj_timer pwmj_chk #(
    .PER_SLOW(PER_SLOW),
    .QSTEPS  (QSTEPS),
    .BLANK   (BLANK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .gate_on  (gate_on),
    .cyc_start(cyc_start),
    .end_stb  (end_stb),
    .end_cause(end_cause)
);

// File: tb/tb_pwmj_timer.sv
module tb_pwmj_timer;

    localparam int PS = 200;
    localparam int Q  = 2;
    localparam int BL = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       fast_mode = 1'b0;
    logic       trip = 1'b0;
    logic       gate_on, cyc_start, end_stb;
    logic [1:0] end_cause;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    pwmj_timer #(.PER_SLOW(PS), .QSTEPS(Q), .BLANK(BL)) dut (
        .clk(clk), .rst(rst), .en(en), .fast_mode(fast_mode), .trip(trip),
        .gate_on(gate_on), .cyc_start(cyc_start), .end_stb(end_stb), .end_cause(end_cause)
    );

    always #4 clk = ~clk;

    function automatic int nom_of(input logic f);
        return f ? PS / 2 : PS;
    endfunction
    function automatic int step_of(input logic f);
        return (nom_of(f) * 7 / 100) / Q;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference model
    int m_cnt, m_per, m_k, m_dir, m_pace, m_on, m_early, m_start, m_stb, m_cause;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_on = 0; m_early = 0; m_start = 0; m_stb = 0; m_cause = 0;
            m_k = 0; m_dir = 1; m_pace = 0; m_per = PS;
        end else if (!en) begin
            m_per = nom_of(fast_mode) + m_k * step_of(fast_mode);
            m_cnt = 0; m_on = 0; m_early = 0; m_start = 0; m_stb = 0;
        end else begin
            int  c;
            int  dl;
            bit  wr;
            c  = m_cnt;
            dl = (m_per * 3) / 4;
            wr = (c == m_per - 1);
            m_start = (c == 0);
            m_stb   = 0;
            if (c == 0) begin
                m_on = 1; m_early = 0;
            end else if (m_on == 1) begin
                if (c < BL) begin
                    if (trip) m_early = 1;
                end else if (trip || m_early == 1) begin
                    m_on = 0; m_stb = 1; m_cause = (m_early == 1) ? 3 : 1;
                end else if (c == dl) begin
                    m_on = 0; m_stb = 1; m_cause = 2;
                end
            end
            if (wr) begin
                if (!fast_mode || m_pace == 1) begin
                    m_k = m_k + m_dir;
                    if (m_k == Q)  m_dir = -1;
                    if (m_k == -Q) m_dir = 1;
                end
                m_pace = fast_mode ? 1 - m_pace : 0;
                m_per  = nom_of(fast_mode) + m_k * step_of(fast_mode);
            end
            m_cnt = wr ? 0 : c + 1;
        end
    end

    // Per-clock comparison and measurement monitor
    int per_q[$];
    int wid_q[$];
    int cse_q[$];
    int last_start = -1;
    int wcount = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk("R8 gate_on vs model", int'(gate_on), m_on);
            chk("R8 cyc_start vs model", int'(cyc_start), m_start);
            chk("R8 end_stb vs model", int'(end_stb), m_stb);
            if (end_stb) chk("R5 end_cause vs model", int'(end_cause), m_cause);
        end
        if (cyc_start) begin
            if (last_start >= 0) per_q.push_back(cyc - last_start);
            last_start = cyc;
            wcount = 1;
        end else if (gate_on) begin
            wcount++;
        end
        if (end_stb) begin
            wid_q.push_back(wcount);
            cse_q.push_back(int'(end_cause));
            wcount = 0;
        end
    end

    task automatic clear_meas();
        per_q.delete(); wid_q.delete(); cse_q.delete();
        last_start = -1;
    endtask

    task automatic wait_periods(input int n);
        while (per_q.size() < n) @(negedge clk);
    endtask

    task automatic wait_width();
        while (wid_q.size() == 0) @(negedge clk);
    endtask

    // Trip arrives on the clock n cycles after the gate rose
    task automatic trip_at(input int n);
        @(negedge clk);
        while (!cyc_start) @(negedge clk);
        clear_meas();
        repeat (n - 1) @(negedge clk);
        trip = 1'b1;
        @(negedge clk);
        trip = 1'b0;
        wait_width();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int ks_slow[8] = '{0, 1, 2, 1, 0, -1, -2, -1};
        int ks_fast[8] = '{0, 0, 1, 1, 2, 2, 1, 1};
        int held;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 gate_on in reset", int'(gate_on), 0);
        chk("R1 cyc_start in reset", int'(cyc_start), 0);
        chk("R1 end_stb in reset", int'(end_stb), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 gate_on after reset", int'(gate_on), 0);
        repeat (2) @(negedge clk);

        // R2, R3, R4: slow mode sweep and duty limit
        clear_meas();
        en = 1'b1;
        wait_periods(8);
        chk("R2 slow nominal period", per_q[0], PS);
        for (int i = 0; i < 8; i++)
            chk("R3 slow sweep period", per_q[i], PS + ks_slow[i] * step_of(1'b0));
        chk("R4 duty width cycle 0", wid_q[0], (PS * 3) / 4);
        chk("R4 duty cause cycle 0", cse_q[0], 2);
        chk("R4 duty width cycle 1", wid_q[1], ((PS + step_of(1'b0)) * 3) / 4);

        // R6: trip within blanking
        trip_at(3);
        chk("R6 early trip width", wid_q[0], BL);
        chk("R6 early trip cause", cse_q[0], 3);

        // R6/R5 boundary: trip on the first clock after blanking
        trip_at(BL);
        chk("R6 boundary trip width", wid_q[0], BL);
        chk("R5 boundary trip cause", cse_q[0], 1);

        // R5: trip well after blanking
        trip_at(20);
        chk("R5 trip width", wid_q[0], 20);
        chk("R5 trip cause", cse_q[0], 1);

        // R7: enable low holds outputs and pauses the sweep
        @(negedge clk);
        while (!cyc_start) @(negedge clk);
        repeat (5) @(negedge clk);
        held = m_per;
        en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            chk("R7 gate low while disabled", int'(gate_on), 0);
            chk("R7 no start while disabled", int'(cyc_start), 0);
            @(negedge clk);
        end
        clear_meas();
        en = 1'b1;
        wait_periods(1);
        chk("R7 period kept across disable", per_q[0], held);

        // R2, R3: fast mode from reset
        rst = 1'b1; en = 1'b0; fast_mode = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        clear_meas();
        en = 1'b1;
        wait_periods(8);
        chk("R2 fast nominal period", per_q[0], PS / 2);
        for (int i = 0; i < 8; i++)
            chk("R3 fast sweep period", per_q[i], PS / 2 + ks_fast[i] * step_of(1'b1));
        chk("R4 fast duty width", wid_q[0], ((PS / 2) * 3) / 4);
        chk("R4 fast duty cause", cse_q[0], 2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule